// File: doc/BRIEF.md
# Panel Power Sequencing Controller

This block brings a flat display panel up and takes it down in a fixed order, one rail at a time. It drives three enables: the panel supply, the display control signals and the backlight. The supply comes up first, then the control signals, then the backlight. Power-down runs the same steps in reverse. Every gap between two steps has its own programmable delay, and a single down counter times each gap.

The sequence runs while two control bits are both high: an interface enable and a start request. If either bit drops, the block starts to walk back down from whatever step it has reached. After the supply turns off, the block holds it off for a minimum rest time before a new power-up may begin. Once a power-down has started it runs to the end, even if the enable returns. The current step is also output for status.

Top module: `panel_pwr_seq`

## Requirements
- R1: While reset is applied, all three enables are low and `seq_state` is 0. State codes are 0 idle, 1 control step, 2 lit, 3 rest.
- R2: The sequence runs when `if_en` AND `seq_start` are both high. In state 0 with the supply off and the sequence running, `sup_en` rises at the next clock. If either bit is low, the supply stays off.
- R3: `ctl_en` rises and `seq_state` becomes 1 exactly `dly_up_ctl`+1 clocks after `sup_en` rises, provided the sequence keeps running. `ctl_en` is never high while `sup_en` is low.
- R4: `lit_en` rises and `seq_state` becomes 2 exactly `dly_up_lit`+1 clocks after `ctl_en` rises. `lit_en` is never high unless both other enables are high.
- R5: In state 2, when the sequence stops, `lit_en` falls and `seq_state` becomes 1 at the next clock while `ctl_en` stays high. `ctl_en` then falls `dly_dn_lit`+1 clocks after `lit_en` falls.
- R6: `sup_en` falls and `seq_state` becomes 3 exactly `dly_dn_ctl`+1 clocks after `ctl_en` falls.
- R7: State 3 lasts exactly `dly_rest`+1 clocks with all enables low, and then `seq_state` returns to 0. The supply can only rise again on a later clock.
- R8: In state 0 with the supply on, stopping the sequence turns `sup_en` off and sets `seq_state` to 3 at the next clock.
- R9: In state 1 during power-up, stopping the sequence drops `ctl_en` at the next clock with no change of state. `sup_en` then falls `dly_dn_ctl`+1 clocks later.
- R10: Once a power-down step has begun, running the sequence again does not resume power-up until the block has come back to state 0.
- R11: Each delay input is sampled only at the clock where its step begins. A later change has no effect on the step already running.
- R12: A delay value of 0 completes its step at the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_en | input | 1 | Interface enable bit |
| seq_start | input | 1 | Start-sequence request bit |
| dly_up_ctl | input | CNT_W | Delay from supply on to control on |
| dly_up_lit | input | CNT_W | Delay from control on to backlight on |
| dly_dn_lit | input | CNT_W | Delay from backlight off to control off |
| dly_dn_ctl | input | CNT_W | Delay from control off to supply off |
| dly_rest | input | CNT_W | Minimum supply-off time before a restart |
| sup_en | output | 1 | Panel supply enable |
| ctl_en | output | 1 | Display control enable |
| lit_en | output | 1 | Backlight enable |
| seq_state | output | 2 | Current step code |

## Verification
The bench builds the block with `CNT_W` = 8 instead of 26. With this width the largest delay, 255, takes only 256 clocks, so the all-ones delay case can be checked directly alongside zero and small delays. The counter logic does not depend on the width, so the full-width part counts the same way, only over longer waits.

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_en,
  input  logic             seq_start,
  input  logic [CNT_W-1:0] dly_up_ctl,
  input  logic [CNT_W-1:0] dly_up_lit,
  input  logic [CNT_W-1:0] dly_dn_lit,
  input  logic [CNT_W-1:0] dly_dn_ctl,
  input  logic [CNT_W-1:0] dly_rest,
  output logic             sup_en,
  output logic             ctl_en,
  output logic             lit_en,
  output logic [1:0]       seq_state
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CTRL = 2'd1,
    ST_LIT  = 2'd2,
    ST_REST = 2'd3
  } st_t;

  st_t             st;
  logic [CNT_W-1:0] cnt;
  logic            down;

  wire run  = if_en & seq_start;
  wire done = (cnt == '0);

  assign seq_state = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      down   <= 1'b0;
      sup_en <= 1'b0;
      ctl_en <= 1'b0;
      lit_en <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (!sup_en) begin
            if (run) begin
              sup_en <= 1'b1;
              cnt    <= dly_up_ctl;
            end
          end else if (!run) begin
            sup_en <= 1'b0;
            cnt    <= dly_rest;
            st     <= ST_REST;
          end else if (done) begin
            ctl_en <= 1'b1;
            cnt    <= dly_up_lit;
            down   <= 1'b0;
            st     <= ST_CTRL;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CTRL: begin
          if (ctl_en && (down ? done : !run)) begin
            ctl_en <= 1'b0;
            cnt    <= dly_dn_ctl;
            down   <= 1'b1;
          end else if (ctl_en && !down && done) begin
            lit_en <= 1'b1;
            st     <= ST_LIT;
          end else if (!ctl_en && done) begin
            sup_en <= 1'b0;
            cnt    <= dly_rest;
            st     <= ST_REST;
          end else if (!done) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LIT: begin
          if (!run) begin
            lit_en <= 1'b0;
            cnt    <= dly_dn_lit;
            down   <= 1'b1;
            st     <= ST_CTRL;
          end
        end
        default: begin
          if (done) st <= ST_IDLE;
          else      cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

endmodule

module panel_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       if_en,
  input logic       seq_start,
  input logic       sup_en,
  input logic       ctl_en,
  input logic       lit_en,
  input logic [1:0] seq_state
);
  wire run = if_en & seq_start;

  // R2
  start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd0 && !sup_en && run) |=> sup_en);

  // R3
  ctl_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |-> sup_en);

  // R4
  lit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lit_en |-> (ctl_en && sup_en));

  // R5
  lit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd2 && !run) |=> (seq_state == 2'd1 && !lit_en && ctl_en));

  // R7
  rest_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd3) |-> (!sup_en && !ctl_en && !lit_en));

  // R8
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 2'd0 && sup_en && !run) |=> (seq_state == 2'd3 && !sup_en));
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .if_en(if_en), .seq_start(seq_start),
  .sup_en(sup_en), .ctl_en(ctl_en), .lit_en(lit_en), .seq_state(seq_state)
);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_en = 1'b0, seq_start = 1'b0;
  logic [W-1:0] d_uc = '0, d_ul = '0, d_dl = '0, d_dc = '0, d_rs = '0;
  logic sup_en, ctl_en, lit_en;
  logic [1:0] seq_state;

  int tests = 0, fails = 0, cycles = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  panel_pwr_seq #(.CNT_W(W)) u_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .if_en(if_en), .seq_start(seq_start),
    .dly_up_ctl(d_uc), .dly_up_lit(d_ul), .dly_dn_lit(d_dl),
    .dly_dn_ctl(d_dc), .dly_rest(d_rs),
    .sup_en(sup_en), .ctl_en(ctl_en), .lit_en(lit_en), .seq_state(seq_state)
  );

  task automatic chk(input int act, input int exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase plus remaining-wait integer
  int m_ph = 0, m_wait = 0, m_sup = 0, m_ctl = 0, m_lit = 0, m_down = 0;
  always @(posedge clk or negedge rst_n) begin
    int go;
    go = (if_en && seq_start) ? 1 : 0;
    if (!rst_n) begin
      m_ph = 0; m_wait = 0; m_sup = 0; m_ctl = 0; m_lit = 0; m_down = 0;
    end else begin
      case (m_ph)
        0: if (m_sup == 0) begin
             if (go == 1) begin m_sup = 1; m_wait = int'(d_uc); end
           end else if (go == 0) begin m_sup = 0; m_wait = int'(d_rs); m_ph = 3; end
           else if (m_wait == 0) begin m_ctl = 1; m_wait = int'(d_ul); m_down = 0; m_ph = 1; end
           else m_wait--;
        1: if (m_ctl == 1 && m_down == 1 && m_wait == 0) begin m_ctl = 0; m_wait = int'(d_dc); end
           else if (m_ctl == 1 && m_down == 0 && go == 0) begin m_ctl = 0; m_down = 1; m_wait = int'(d_dc); end
           else if (m_ctl == 1 && m_down == 0 && m_wait == 0) begin m_lit = 1; m_ph = 2; end
           else if (m_ctl == 0 && m_wait == 0) begin m_sup = 0; m_wait = int'(d_rs); m_ph = 3; end
           else if (m_wait > 0) m_wait--;
        2: if (go == 0) begin m_lit = 0; m_down = 1; m_wait = int'(d_dl); m_ph = 1; end
        default: if (m_wait == 0) m_ph = 0; else m_wait--;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(int'(sup_en), m_sup, "R2 model supply");
      chk(int'(ctl_en), m_ctl, "R3 model control");
      chk(int'(lit_en), m_lit, "R4 model backlight");
      chk(int'(seq_state), m_ph, "R7 model state");
    end
  end

  function automatic logic probe(input int sel);
    case (sel)
      0: return sup_en;
      1: return ctl_en;
      2: return lit_en;
      3: return seq_state == 2'd3;
      default: return seq_state == 2'd0;
    endcase
  endfunction

  task automatic gap(input int sel, input logic val, input int exp, input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (probe(sel) !== val && n < 2000);
    chk(n, exp, tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(int'(sup_en), 0, "R1 supply"); chk(int'(ctl_en), 0, "R1 control");
    chk(int'(lit_en), 0, "R1 backlight"); chk(int'(seq_state), 0, "R1 state");
    rst_n = 1'b1;
    d_uc = 3; d_ul = 4; d_dl = 2; d_dc = 5; d_rs = 6;
    if_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(sup_en), 0, "R2 start bit low");
    seq_start = 1'b1;
    @(negedge clk); chk(int'(sup_en), 1, "R2 supply on");
    gap(1, 1'b1, 4, "R3 control delay"); chk(int'(seq_state), 1, "R3 state");
    d_ul = 77;
    gap(2, 1'b1, 5, "R11 sampled delay"); chk(int'(seq_state), 2, "R4 state");
    d_ul = 4;
    repeat (3) @(negedge clk);
    seq_start = 1'b0;
    @(negedge clk);
    chk(int'(lit_en), 0, "R5 backlight off"); chk(int'(ctl_en), 1, "R5 control held");
    chk(int'(seq_state), 1, "R5 state");
    gap(1, 1'b0, 3, "R5 control off delay");
    gap(0, 1'b0, 6, "R6 supply off delay"); chk(int'(seq_state), 3, "R6 state");
    seq_start = 1'b1;
    gap(4, 1'b1, 7, "R7 rest length");
    chk(int'(sup_en), 0, "R7 no early restart");
    @(negedge clk); chk(int'(sup_en), 1, "R2 restart");
    seq_start = 1'b0;
    @(negedge clk);
    chk(int'(sup_en), 0, "R8 supply off"); chk(int'(seq_state), 3, "R8 state");
    gap(4, 1'b1, 7, "R7 rest after abort");
    seq_start = 1'b1;
    @(negedge clk); chk(int'(sup_en), 1, "R2 supply again");
    gap(1, 1'b1, 4, "R3 control again");
    repeat (2) @(negedge clk);
    seq_start = 1'b0;
    @(negedge clk);
    chk(int'(ctl_en), 0, "R9 control off"); chk(int'(seq_state), 1, "R9 state");
    seq_start = 1'b1;
    gap(0, 1'b0, 6, "R10 power-down continues");
    chk(int'(seq_state), 3, "R10 state");
    gap(4, 1'b1, 7, "R7 rest third");
    @(negedge clk); chk(int'(sup_en), 1, "R10 power-up after idle");
    gap(1, 1'b1, 4, "R3 control third");
    gap(2, 1'b1, 5, "R4 backlight delay");
    d_uc = 0; d_ul = 0; d_dl = 0; d_dc = 0; d_rs = 0;
    seq_start = 1'b0;
    @(negedge clk); chk(int'(lit_en), 0, "R12 backlight off");
    seq_start = 1'b1;
    gap(1, 1'b0, 1, "R12 control off");
    gap(0, 1'b0, 1, "R12 supply off");
    gap(4, 1'b1, 1, "R12 rest");
    @(negedge clk); chk(int'(sup_en), 1, "R12 supply on");
    gap(1, 1'b1, 1, "R12 control on");
    gap(2, 1'b1, 1, "R12 backlight on");
    d_dl = '1; d_dc = '1; d_rs = '1;
    seq_start = 1'b0;
    @(negedge clk); chk(int'(lit_en), 0, "R5 backlight off max");
    gap(1, 1'b0, 256, "R5 max delay");
    gap(0, 1'b0, 256, "R6 max delay");
    gap(4, 1'b1, 256, "R7 max rest");
    repeat (2) @(negedge clk);
    chk(int'(sup_en), 0, "R2 stays off");
    done_flag = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule